// File: doc/BRIEF.md
# Masked Interrupt Flag Register

This block gathers four hardware event sources into sticky pending bits for an 8-bit core. The sources are a timer overflow pulse, an active-low external request pin, an SPI transfer-done pulse and a compare-match pulse from a second timer. An 8-bit enable mask sits next to the pending bits. A single interrupt request line goes to the core. It is high whenever any pending bit has its mask bit set.

Software reaches the block over a one-bit-address register port. Address 0 is the status view. A read there returns the pending bits ANDed with the mask. A write there can only clear pending bits, never set them. Address 1 is the mask, which reads back in full. The external pin is synchronized by two flops and then passed to a falling-edge detector. Each falling edge yields exactly one set pulse.

Top module: `irq_status_top`

## Requirements
- R1: After synchronous reset, all pending bits and the mask are 0, `irq_req` is 0 and reads of both addresses return 0x00.
- R2: A one-cycle high on `tmr0_ovf` sets pending bit 0, and the bit is visible at the first clock edge after the pulse.
- R3: A high-to-low transition on `ext_irq_n` sets pending bit 1 at the third clock edge after the pin goes low. Holding the pin low gives no further set after the bit is cleared, and a low-to-high transition sets nothing.
- R4: A one-cycle high on `spi_done` sets pending bit 2 at the next clock edge.
- R5: A one-cycle high on `tmr1_match` sets pending bit 3 at the next clock edge.
- R6: Status bits 7..4 always read as 0, even with the mask at 0xFF and all sources pending.
- R7: A read at address 0 returns the pending bits ANDed with the mask. A pending bit whose mask bit is 0 reads as 0 until the mask bit is set.
- R8: A write to address 0 clears each pending bit whose data bit is 0. Pending bits whose data bit is 1 are left as they were.
- R9: A write to address 0 never sets a pending bit, even when the data is 0xFF.
- R10: When a source set and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R11: `irq_req` equals the OR of (pending AND mask) as it stood one clock edge earlier.
- R12: A write to address 1 loads the whole 8-bit mask, and a read at address 1 returns it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr0_ovf | input | 1 | Timer overflow event pulse |
| ext_irq_n | input | 1 | Asynchronous external request pin, active low |
| spi_done | input | 1 | SPI transfer-complete pulse |
| tmr1_match | input | 1 | Second timer compare-match pulse |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 1 | 0 selects status, 1 selects mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq_req | output | 1 | Registered interrupt request to the core |

## Verification
Each result has a fixed latency, which the checks follow:
- A pulse source or a register write takes effect at the first clock edge.
- The external pin needs three edges: two synchronizer stages, then the pending-bit register.
- `irq_req` follows a pending-bit or mask change one edge later.
- `bus_rdata` is combinational from the registers and the address.

The bench drives stimulus at falling clock edges and advances a counted number of rising edges. It samples at the next falling edge, so each check lands on the cycle its requirement names. Just before the due edge it also checks that the result has not yet appeared.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int DATA_W  = 8;
    localparam int NUM_SRC = 4;

    // bit positions of the pending sources; software decodes these
    typedef enum int unsigned {
        SRC_TMR0 = 0,
        SRC_EXT  = 1,
        SRC_SPI  = 2,
        SRC_TMR1 = 3
    } src_e;

    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_MASK   = 1'b1;

    typedef struct packed {
        logic              stat_we;
        logic              mask_we;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    function automatic reg_wr_t decode_wr(input logic wr, input logic addr,
                                          input logic [DATA_W-1:0] data);
        reg_wr_t r;
        r.stat_we = wr && (addr == ADDR_STATUS);
        r.mask_we = wr && (addr == ADDR_MASK);
        r.data    = data;
        return r;
    endfunction

endpackage

// File: rtl/irq_fall_detect.sv
module irq_fall_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_n};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign fall = last_q & ~sync_q[STAGES-1];

    AST_ONE_SET_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall) else $error("double set pulse");   // R3

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_we,
    input  logic [N-1:0] keep_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;
    logic [N-1:0] flags_d;

    always_comb begin
        flags_d = flags_q;
        if (clr_we) flags_d = flags_d & keep_i;
        flags_d = flags_d | set_i;   // set wins over a clear in the same cycle
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)))
        else $error("set event lost");   // R10

    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
        (set_i == '0) |=> ((flags_q & ~$past(flags_q)) == '0))
        else $error("flag rose without event");   // R9

    AST_CLEAR_ZEROS: assert property (@(posedge clk) disable iff (rst)
        (clr_we && set_i == '0) |=> ((flags_q & ~$past(keep_i)) == '0))
        else $error("cleared flag survived");   // R8

endmodule

// File: rtl/irq_status_top.sv
module irq_status_top
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr0_ovf,
    input  logic              ext_irq_n,
    input  logic              spi_done,
    input  logic              tmr1_match,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_req
);
    localparam int PAD_W = DATA_W - NUM_SRC;

    logic [NUM_SRC-1:0] src_set;
    logic [NUM_SRC-1:0] pending;
    logic [DATA_W-1:0]  pend_wide;
    logic [DATA_W-1:0]  mask_q;
    logic               irq_q;
    logic               ext_fall;
    reg_wr_t            wr;

    assign wr = decode_wr(bus_wr, bus_addr, bus_wdata);

    irq_fall_detect #(.STAGES(SYNC_STAGES)) u_ext (
        .clk   (clk),
        .rst   (rst),
        .pin_n (ext_irq_n),
        .fall  (ext_fall)
    );

    always_comb begin
        src_set           = '0;
        src_set[SRC_TMR0] = tmr0_ovf;
        src_set[SRC_EXT]  = ext_fall;
        src_set[SRC_SPI]  = spi_done;
        src_set[SRC_TMR1] = tmr1_match;
    end

    irq_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (src_set),
        .clr_we  (wr.stat_we),
        .keep_i  (wr.data[NUM_SRC-1:0]),
        .flags_o (pending)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign pend_wide = {{PAD_W{1'b0}}, pending};
        end else begin : g_nopad
            assign pend_wide = pending;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr.mask_we) mask_q <= wr.data;
            irq_q <= |(pend_wide & mask_q);
        end
    end

    assign bus_rdata = (bus_addr == ADDR_MASK) ? mask_q : (pend_wide & mask_q);
    assign irq_req   = irq_q;

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_req == $past(|(pending & mask_q[NUM_SRC-1:0]))))
        else $error("request mismatch");   // R11

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_STATUS) |-> (bus_rdata[DATA_W-1:NUM_SRC] == '0))
        else $error("unused status bits nonzero");   // R6

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_MASK) |=> (mask_q == $past(bus_wdata)))
        else $error("mask not loaded");   // R12

endmodule

// File: tb/irq_status_top_test.sv
module irq_status_top_test;
    localparam time CLK_P = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tmr0_ovf = 1'b0, ext_irq_n = 1'b1, spi_done = 1'b0, tmr1_match = 1'b0;
    logic       bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_status_top uut (
        .clk(clk), .rst(rst), .tmr0_ovf(tmr0_ovf), .ext_irq_n(ext_irq_n),
        .spi_done(spi_done), .tmr1_match(tmr1_match), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req)
    );

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic read_stat(output logic [7:0] v);
        bus_addr = 1'b0; #1; v = bus_rdata;
    endtask

    task automatic read_mask(output logic [7:0] v);
        bus_addr = 1'b1; #1; v = bus_rdata; bus_addr = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        read_stat(v); chk("R1 status", v, 8'h00);
        read_mask(v); chk("R1 mask", v, 8'h00);
        chk("R1 irq", {7'b0, irq_req}, 8'h00);
    endtask

    task automatic t_mask_rw();
        logic [7:0] v;
        bus_write(1'b1, 8'hA5);
        read_mask(v); chk("R12 mask A5", v, 8'hA5);
        bus_write(1'b1, 8'hFF);
        read_mask(v); chk("R12 mask FF", v, 8'hFF);
    endtask

    task automatic t_timer0();
        logic [7:0] v;
        tmr0_ovf = 1'b1; tick(); tmr0_ovf = 1'b0;
        read_stat(v); chk("R2 timer flag", v, 8'h01);
        chk("R11 irq not yet", {7'b0, irq_req}, 8'h00);
        tick();
        chk("R11 irq raised", {7'b0, irq_req}, 8'h01);
        bus_write(1'b0, 8'hFE);
        read_stat(v); chk("R8 cleared bit0", v, 8'h00);
        tick();
        chk("R11 irq dropped", {7'b0, irq_req}, 8'h00);
    endtask

    task automatic t_ext();
        logic [7:0] v;
        ext_irq_n = 1'b0;
        tick(2);
        read_stat(v); chk("R3 not yet after 2 edges", v, 8'h00);
        tick();
        read_stat(v); chk("R3 set after 3 edges", v, 8'h02);
        bus_write(1'b0, 8'hFD);
        tick(5);
        read_stat(v); chk("R3 held low no reset", v, 8'h00);
        ext_irq_n = 1'b1;
        tick(5);
        read_stat(v); chk("R3 rising edge ignored", v, 8'h00);
    endtask

    task automatic t_spi_tm1();
        logic [7:0] v;
        spi_done = 1'b1; tick(); spi_done = 1'b0;
        read_stat(v); chk("R4 spi flag", v, 8'h04);
        bus_write(1'b0, 8'h00);
        tmr1_match = 1'b1; tick(); tmr1_match = 1'b0;
        read_stat(v); chk("R5 tmr1 flag", v, 8'h08);
        bus_write(1'b0, 8'h00);
        read_stat(v); chk("R8 clear all", v, 8'h00);
        tick(2);
    endtask

    task automatic t_all_and_keep();
        logic [7:0] v;
        tmr0_ovf = 1'b1; spi_done = 1'b1; tmr1_match = 1'b1; ext_irq_n = 1'b0;
        tick(); tmr0_ovf = 1'b0; spi_done = 1'b0; tmr1_match = 1'b0;
        tick(2);
        read_stat(v); chk("R6 upper zero", v, 8'h0F);
        bus_write(1'b0, 8'hFF);
        read_stat(v); chk("R8 ones keep", v, 8'h0F);
        bus_write(1'b0, 8'hF5);
        read_stat(v); chk("R8 partial clear", v, 8'h05);
        bus_write(1'b0, 8'h00);
        ext_irq_n = 1'b1;
        tick(4);
    endtask

    task automatic t_no_sw_set();
        logic [7:0] v;
        bus_write(1'b0, 8'hFF);
        tick();
        read_stat(v); chk("R9 write cannot set", v, 8'h00);
        chk("R9 irq stays low", {7'b0, irq_req}, 8'h00);
    endtask

    task automatic t_masked();
        logic [7:0] v;
        bus_write(1'b1, 8'h01);
        spi_done = 1'b1; tick(); spi_done = 1'b0;
        read_stat(v); chk("R7 masked reads 0", v, 8'h00);
        tick(2);
        chk("R11 masked no irq", {7'b0, irq_req}, 8'h00);
        bus_write(1'b1, 8'h04);
        read_stat(v); chk("R7 unmasked reads", v, 8'h04);
        chk("R11 irq one edge after mask", {7'b0, irq_req}, 8'h00);
        tick();
        chk("R11 irq after unmask", {7'b0, irq_req}, 8'h01);
        bus_write(1'b0, 8'h00);
        bus_write(1'b1, 8'hFF);
        tick();
    endtask

    task automatic t_collision();
        logic [7:0] v;
        tmr1_match = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h00;
        tick();
        tmr1_match = 1'b0; bus_wr = 1'b0;
        read_stat(v); chk("R10 set wins", v, 8'h08);
        bus_write(1'b0, 8'h00);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        t_reset();
        t_mask_rw();
        t_timer0();
        t_ext();
        t_spi_tm1();
        t_all_and_keep();
        t_no_sw_set();
        t_masked();
        t_collision();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule